// File: doc/BRIEF.md
# Sub-picture decimating field writer

This block takes a digitised sub-picture as a stream of samples: an 8-bit luma value together with one 8-bit colour-difference value that alternates between B-Y and R-Y from sample to sample. It also takes a horizontal and a vertical sync. It shrinks that picture to one third or one quarter of its size in each direction. Luma is box-averaged over the source lines that fold into one stored row, then reduced to 6 bits. Chroma is reduced to 6 bits with no vertical filter. The result is written into an on-chip field memory sized for the larger picture.

Each stored row holds a fixed number of luma words. Every third word also carries one chroma sample, and those chroma samples alternate between B-Y and R-Y. The number of rows per field depends on the size mode. A freeze request is taken only at the start of a field, so a stored field is never left half-written. A registered read port lets the display side fetch stored words.

Top module: `spd_field_writer`

## Requirements
- R1: `size_sel` is sampled on each rising edge of `vsync` and selects a shrink ratio N: 0 gives N=3 and 1 gives N=4. Within a line, the sample count restarts on the rising edge of `hsync`, and only samples whose index within the line is a multiple of N are kept.
- R2: The first line after the rising edge of `vsync` begins row 0. Every N lines form one row. Kept sample k of row r is written to word address r*COLS+k, and only the first COLS kept samples of a line are stored.
- R3: Bits [5:0] of a stored word are the upper 6 bits of the rounded mean of the N luma values in that column, one from each line of the row. The mean is computed as (sum+1)/3 for N=3 and (sum+2)/4 for N=4.
- R4: When k is a multiple of CSTEP, bits [11:6] hold the upper 6 bits of a colour-difference sample taken from the last line of the row. Even chroma slots hold the most recent B-Y sample (`c_is_r`=0) and odd slots hold the most recent R-Y sample, both at or before the kept sample. All other words hold 0 in bits [11:6], and bits [17:12] are always 0.
- R5: A field stores at most ROWS_NINTH rows when N=3 and at most ROWS_SIXTEENTH rows when N=4. Lines beyond that limit leave the memory unchanged.
- R6: `freeze` is sampled on each rising edge of `vsync`. When it is high, no word is written during that field, and the previously stored field stays intact.
- R7: `rd_data` returns the word at `rd_addr` one clock cycle after the address is presented, and it reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical sync; its rising edge starts a field |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| sample_vld | input | 1 | High for each cycle that carries an active sample |
| y_in | input | IN_W | Luma sample |
| c_in | input | IN_W | Colour-difference sample |
| c_is_r | input | 1 | 1 when `c_in` is R-Y, 0 when it is B-Y |
| size_sel | input | 1 | 0 selects one third per axis, 1 selects one quarter per axis |
| freeze | input | 1 | Hold the stored field, starting at the next field |
| rd_addr | input | AW | Read word address |
| rd_data | output | 18 | Read word: {spare, chroma, luma}, 6 bits each |

## Verification
The bench builds the block with COLS=6, ROWS_NINTH=4, ROWS_SIXTEENTH=3 and CSTEP=3. With these values a whole field takes only a few hundred cycles. That makes it practical to run three fields in a row: a one-third field, a frozen field, and a one-quarter field. Because the smaller mode's row cap falls below the memory depth, the last row written by the first field must survive the quarter-size field. This exposes any write past the row limit. Each line also carries extra samples and each field carries extra lines, so the column and row caps are exercised on every line.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int Q_W = 6;

    typedef struct packed {
        logic [Q_W-1:0] spare;
        logic [Q_W-1:0] chroma;
        logic [Q_W-1:0] luma;
    } spd_word_t;

    typedef enum logic {
        SZ_THIRD   = 1'b0,
        SZ_QUARTER = 1'b1
    } spd_size_e;
endpackage

// File: rtl/spd_col_track.sv
module spd_col_track #(
    parameter int COLS  = 171,
    parameter int CSTEP = 3,
    parameter int COL_W = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             sample_vld,
    input  logic [2:0]       ratio,
    output logic             keep,
    output logic [COL_W-1:0] col,
    output logic             chroma_slot,
    output logic             chroma_odd
);
    localparam int CS_W = (CSTEP > 1) ? $clog2(CSTEP) : 1;

    typedef struct packed {
        logic [2:0]       phase;
        logic [COL_W-1:0] col;
        logic [CS_W-1:0]  cstep;
        logic             codd;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        keep = sample_vld && (st_q.phase == 3'd0) && (32'(st_q.col) < COLS);
        if (line_start) begin
            st_d = '0;
        end else if (sample_vld) begin
            st_d.phase = (st_q.phase == ratio - 3'd1) ? 3'd0 : st_q.phase + 3'd1;
            if (keep) begin
                st_d.col = st_q.col + COL_W'(1);
                if (st_q.cstep == '0) st_d.codd = ~st_q.codd;
                st_d.cstep = (32'(st_q.cstep) == CSTEP - 1) ? '0 : st_q.cstep + CS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col         = st_q.col;
    assign chroma_slot = (st_q.cstep == '0);
    assign chroma_odd  = st_q.codd;

    assert_col_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.col) <= COLS);
    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !line_start) |=> (st_q.phase < 3'd4));
endmodule

// File: rtl/spd_row_track.sv
module spd_row_track #(
    parameter int ROWS_NINTH     = 69,
    parameter int ROWS_SIXTEENTH = 52,
    parameter int ROW_W          = $clog2(ROWS_NINTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_start,
    input  logic             size_in,
    input  logic             freeze_in,
    output logic [2:0]       ratio,
    output logic [ROW_W-1:0] row,
    output logic             first_line,
    output logic             last_line,
    output logic             row_ok,
    output logic             frozen
);
    import spd_pkg::*;

    typedef struct packed {
        logic [1:0]       lgrp;
        logic [ROW_W-1:0] row;
        logic             started;
        logic             frozen;
        spd_size_e        size;
    } row_st_t;

    row_st_t          st_d, st_q;
    logic [ROW_W-1:0] limit;

    always_comb begin
        ratio = (st_q.size == SZ_QUARTER) ? 3'd4 : 3'd3;
        limit = (st_q.size == SZ_QUARTER) ? ROW_W'(ROWS_SIXTEENTH) : ROW_W'(ROWS_NINTH);
        st_d  = st_q;
        if (field_start) begin
            st_d.lgrp    = '0;
            st_d.row     = '0;
            st_d.started = 1'b0;
            st_d.frozen  = freeze_in;
            st_d.size    = spd_size_e'(size_in);
        end else if (line_start) begin
            st_d.started = 1'b1;
            if (st_q.started) begin
                if ({1'b0, st_q.lgrp} == ratio - 3'd1) begin
                    st_d.lgrp = '0;
                    if (st_q.row < limit) st_d.row = st_q.row + ROW_W'(1);
                end else begin
                    st_d.lgrp = st_q.lgrp + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lgrp: '0, row: '0, started: 1'b0, frozen: 1'b0, size: SZ_THIRD};
        else        st_q <= st_d;
    end

    assign row        = st_q.row;
    assign first_line = (st_q.lgrp == 2'd0);
    assign last_line  = st_q.started && ({1'b0, st_q.lgrp} == ratio - 3'd1);
    assign row_ok     = st_q.started && (st_q.row < limit);
    assign frozen     = st_q.frozen;

    assert_row_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row <= limit);
    assert_group_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.lgrp} < ratio);
    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(st_q.frozen));
endmodule

// File: rtl/spd_luma_box.sv
module spd_luma_box #(
    parameter int COLS  = 171,
    parameter int IN_W  = 8,
    parameter int COL_W = $clog2(COLS + 1)
) (
    input  logic                      clk,
    input  logic                      keep,
    input  logic [COL_W-1:0]          col,
    input  logic                      first_line,
    input  logic [2:0]                ratio,
    input  logic [IN_W-1:0]           y_in,
    output logic [spd_pkg::Q_W-1:0]   y_q6
);
    import spd_pkg::*;
    localparam int SUM_W = IN_W + 2;

    logic [SUM_W-1:0] acc_q [COLS];
    logic [SUM_W-1:0] acc_rd, sum_d;
    logic [SUM_W:0]   avg;

    always_comb begin
        acc_rd = (32'(col) < COLS) ? acc_q[col] : '0;
        sum_d  = first_line ? SUM_W'(y_in) : acc_rd + SUM_W'(y_in);
        if (ratio == 3'd4) avg = ({1'b0, sum_d} + (SUM_W+1)'(2)) >> 2;
        else               avg = ({1'b0, sum_d} + (SUM_W+1)'(1)) / (SUM_W+1)'(3);
        y_q6 = avg[IN_W-1 -: Q_W];
    end

    always_ff @(posedge clk) begin
        if (keep && (32'(col) < COLS)) acc_q[col] <= sum_d;
    end

    assert_ratio_R1: assert property (@(posedge clk)
        keep |-> (ratio == 3'd3 || ratio == 3'd4));
endmodule

// File: rtl/spd_field_ram.sv
module spd_field_ram #(
    parameter int DEPTH = 11799,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    assert_wr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < DEPTH));
endmodule

// File: rtl/spd_field_writer.sv
module spd_field_writer #(
    parameter int COLS           = 171,
    parameter int ROWS_NINTH     = 69,
    parameter int ROWS_SIXTEENTH = 52,
    parameter int CSTEP          = 3,
    parameter int IN_W           = 8,
    parameter int AW             = $clog2(COLS * ROWS_NINTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vsync,
    input  logic            hsync,
    input  logic            sample_vld,
    input  logic [IN_W-1:0] y_in,
    input  logic [IN_W-1:0] c_in,
    input  logic            c_is_r,
    input  logic            size_sel,
    input  logic            freeze,
    input  logic [AW-1:0]   rd_addr,
    output logic [17:0]     rd_data
);
    import spd_pkg::*;

    localparam int DEPTH = COLS * ROWS_NINTH;
    localparam int COL_W = $clog2(COLS + 1);
    localparam int ROW_W = $clog2(ROWS_NINTH + 1);

    typedef struct packed {
        logic            vs;
        logic            hs;
        logic [IN_W-1:0] cb;
        logic [IN_W-1:0] cr;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             field_start, line_start;
    logic [IN_W-1:0]  cb_now, cr_now, c_pick;
    logic             keep, chroma_slot, chroma_odd;
    logic [COL_W-1:0] col;
    logic [2:0]       ratio;
    logic [ROW_W-1:0] row;
    logic             first_line, last_line, row_ok, frozen;
    logic [Q_W-1:0]   y_q6;
    spd_word_t        wr_word;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;

    always_comb begin
        field_start = vsync & ~st_q.vs;
        line_start  = hsync & ~st_q.hs;
        cb_now = (sample_vld && !c_is_r) ? c_in : st_q.cb;
        cr_now = (sample_vld &&  c_is_r) ? c_in : st_q.cr;
        c_pick = chroma_odd ? cr_now : cb_now;

        st_d    = st_q;
        st_d.vs = vsync;
        st_d.hs = hsync;
        st_d.cb = cb_now;
        st_d.cr = cr_now;

        wr_word.spare  = '0;
        wr_word.luma   = y_q6;
        wr_word.chroma = chroma_slot ? c_pick[IN_W-1 -: Q_W] : '0;
        wr_en   = keep && last_line && row_ok && !frozen;
        wr_addr = AW'(32'(row) * COLS + 32'(col));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    spd_col_track #(.COLS(COLS), .CSTEP(CSTEP), .COL_W(COL_W)) u_col (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .sample_vld(sample_vld),
        .ratio(ratio), .keep(keep), .col(col), .chroma_slot(chroma_slot),
        .chroma_odd(chroma_odd)
    );

    spd_row_track #(.ROWS_NINTH(ROWS_NINTH), .ROWS_SIXTEENTH(ROWS_SIXTEENTH),
                    .ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
        .size_in(size_sel), .freeze_in(freeze), .ratio(ratio), .row(row),
        .first_line(first_line), .last_line(last_line), .row_ok(row_ok), .frozen(frozen)
    );

    spd_luma_box #(.COLS(COLS), .IN_W(IN_W), .COL_W(COL_W)) u_luma (
        .clk(clk), .keep(keep), .col(col), .first_line(first_line), .ratio(ratio),
        .y_in(y_in), .y_q6(y_q6)
    );

    spd_field_ram #(.DEPTH(DEPTH), .AW(AW), .W(18)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_word),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assert_frozen_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !wr_en);
    assert_write_last_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (last_line && !first_line));
    assert_write_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(row) < ROWS_NINTH));
    assert_write_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(col) < COLS));
endmodule

// File: tb/spd_field_writer_test.sv
module spd_field_writer_test;
    localparam int COLS = 6;
    localparam int RN   = 4;
    localparam int RS   = 3;
    localparam int CS   = 3;
    localparam int DEPTH = COLS * RN;
    localparam int AW   = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 0, hsync = 0, sample_vld = 0, c_is_r = 0, size_sel = 0, freeze = 0;
    logic [7:0] y_in = 0, c_in = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [17:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [17:0] exp_mem [DEPTH];
    logic [17:0] exp_q [$];
    string tag_q [$];
    logic issue = 1'b0;
    logic due = 1'b0;

    always #2.5 clk = ~clk;

    spd_field_writer #(.COLS(COLS), .ROWS_NINTH(RN), .ROWS_SIXTEENTH(RS),
                       .CSTEP(CS), .IN_W(8), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .sample_vld(sample_vld),
        .y_in(y_in), .c_in(c_in), .c_is_r(c_is_r), .size_sel(size_sel), .freeze(freeze),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int yv(int f, int l, int s);
        return (f * 53 + l * 29 + s * 7 + 5) & 255;
    endfunction

    function automatic int cv(int f, int l, int s);
        return (f * 17 + l * 13 + s * 19 + 90) & 255;
    endfunction

    task automatic run_field(int f, bit sz, bit frz);
        int n    = sz ? 4 : 3;
        int rows = sz ? RS : RN;
        int lines = rows * n + n;
        int spl  = COLS * n + 2;
        @(negedge clk);
        size_sel = sz; freeze = frz; vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        for (int l = 0; l < lines; l++) begin
            hsync = 1'b1;
            @(negedge clk);
            hsync = 1'b0;
            for (int s = 0; s < spl; s++) begin
                sample_vld = 1'b1;
                y_in = 8'(yv(f, l, s));
                c_in = 8'(cv(f, l, s));
                c_is_r = s[0];
                @(negedge clk);
            end
            sample_vld = 1'b0;
            @(negedge clk);
        end
        if (!frz) begin
            for (int r = 0; r < rows; r++) begin
                for (int k = 0; k < COLS; k++) begin
                    int sum = 0;
                    int avg, cval, sidx, s0;
                    logic [17:0] w;
                    s0 = k * n;
                    for (int j = 0; j < n; j++) sum += yv(f, r * n + j, s0);
                    avg = (sum + n / 2) / n;
                    w = '0;
                    w[5:0] = 6'(avg >> 2);
                    if (k % CS == 0) begin
                        sidx = ((s0 & 1) == ((k / CS) & 1)) ? s0 : s0 - 1;
                        cval = cv(f, r * n + n - 1, sidx);
                        w[11:6] = 6'(cval >> 2);
                    end
                    exp_mem[r * COLS + k] = w;
                end
            end
        end
    endtask

    // driver side of the scoreboard: push expected word, present address
    task automatic read_all(string tag);
        for (int a = 0; a < DEPTH; a++) begin
            exp_q.push_back(exp_mem[a]);
            tag_q.push_back(tag);
            rd_addr = AW'(a);
            issue = 1'b1;
            @(negedge clk);
        end
        issue = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) due <= issue;

    // monitor side: one cycle after each issued address
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            logic [17:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: word mismatch actual=%h expected=%h", t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== 18'h0) begin
            errors++;
            $display("FAIL R7: reset read actual=%h expected=0", rd_data);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4: one-third field fills every row
        run_field(1, 1'b0, 1'b0);
        read_all("R1 R2 R3 R4 R7 third-size field");

        // R6: frozen field leaves stored words intact
        run_field(2, 1'b1, 1'b1);
        read_all("R6 frozen field");

        // R1 R5: quarter-size field rewrites only its rows; last third-size row survives
        run_field(3, 1'b1, 1'b0);
        read_all("R1 R5 quarter-size field");

        // R5 R6: a later third-size field after freeze released overwrites all rows
        run_field(4, 1'b0, 1'b0);
        read_all("R2 R5 second third-size field");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule